// File: doc/BRIEF.md
# I2C Serial Clock Generator with Bus Synchronization

This block produces the serial clock for an I2C controller that is acting as bus master, either transmitting or receiving. The clock line is open-drain and wired-AND, so the block only ever pulls the line low or lets it go. Software sets two counts, in system clock cycles: one for the time the line is held low and one for the time it is left high. Together they set both the bit rate and the duty cycle.

The generator follows the real line rather than running free. If any other device pulls the clock low during the high phase, the high phase ends at once and a new low phase begins. If another device is still holding the line low when the local low count runs out, the generator releases the line and waits, and it starts the high count only once the line is seen high. The byte-handling logic can raise a hold request, which is the interrupt flag set after a byte and its acknowledge bit. While that request is set, the generator keeps the line low at the end of the low phase.

The line is brought in through a synchronizer. One-cycle pulses mark each rising and falling edge seen on the line, for use by the shift and acknowledge logic. When master mode is off, the generator lets go of the line and clears its counter.

Top module: `scl_clock_gen`

## Requirements
- R1: While `master_en` is low, `scl_pull_low` is 0 from the clock edge after it is sampled low, and the line is never pulled.
- R2: With no other device on the line, each low phase lasts exactly max(`low_count`, 4) clock cycles.
- R3: With no other device on the line, each high phase lasts exactly max(`high_count`, 4) clock cycles. This is measured from the cycle the line goes high, and the 3 cycles of synchronizer and state delay count toward it.
- R4: Any count value below 4 is treated as 4, for both the low phase and the high phase.
- R5: If another device pulls the line low during the high phase, the block asserts `scl_pull_low` within 3 cycles. The resulting low time, counted from the moment the line fell, is max(`low_count`, 4).
- R6: If the line is still low when the local low count ends, the block deasserts `scl_pull_low` and does not start its high count until the line is sampled high. The high phase then lasts max(`high_count`, 4) cycles from the line's rise.
- R7: If `hold_req` is 1 when the low count ends, `scl_pull_low` stays at 1 for as long as `hold_req` stays at 1. It drops one clock after `hold_req` is sampled 0.
- R8: `scl_fall` is a one-cycle pulse in the 3rd cycle after the line falls, and `scl_rise` is a one-cycle pulse in the 3rd cycle after the line rises. The two pulses are never high together.
- R9: During reset, `scl_pull_low`, `scl_rise` and `scl_fall` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | 1 while the controller is a master (transmit or receive) |
| low_count | input | CNT_W | Low-phase length in clock cycles (minimum 4) |
| high_count | input | CNT_W | High-phase length in clock cycles (minimum 4) |
| scl_in | input | 1 | Raw level of the shared clock line |
| hold_req | input | 1 | Interrupt flag from the byte logic; holds the line low at the end of the low phase |
| scl_pull_low | output | 1 | 1 drives the open-drain clock line low |
| scl_rise | output | 1 | One-cycle pulse on a detected rising edge of the line |
| scl_fall | output | 1 | One-cycle pulse on a detected falling edge of the line |

## Verification
On every cycle, the assertions check a set of local rules. The line is released once master mode drops, and the high count never starts while the synchronized line is low. The high phase begins only after the line has been seen high. An external pull or a hold request forces the pull-low output on the next cycle, and the edge pulses are single-cycle and mutually exclusive. The exact phase lengths under different count settings, including the clamp, cannot be shown by these rules alone. The bench's scenarios show those, together with how the generator behaves against a second device on a wired-AND line that cuts a high phase short or stretches a low phase.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;

  // Raise a programmed length to the floor value.
  function automatic logic [31:0] clamp_count(input logic [31:0] req,
                                              input logic [31:0] floor_v);
    return (req < floor_v) ? floor_v : req;
  endfunction

  // Last counter value of a phase that lasts len cycles.
  function automatic logic [31:0] last_tick(input logic [31:0] len);
    return len - 32'd1;
  endfunction

endpackage

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  output logic scl_s,
  output logic scl_rise,
  output logic scl_fall
);

  logic stage_q [STAGES];
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= 1'b1;
    else        stage_q[0] <= scl_in;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= 1'b1;
      else        stage_q[i] <= stage_q[i-1];
    end
  end

  assign scl_s = stage_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= scl_s;
  end

  assign scl_rise = scl_s & ~prev_q;
  assign scl_fall = ~scl_s & prev_q;

  // R8: edge pulses never coincide and last one cycle
  a_r8_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_rise && scl_fall));
  a_r8_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |=> !scl_rise);
  a_r8_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |=> !scl_fall);

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_gen_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SYNC_LAT  = 3,
  parameter int MIN_COUNT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_en,
  input  logic [CNT_W-1:0] low_count,
  input  logic [CNT_W-1:0] high_count,
  input  logic             scl_s,
  input  logic             hold_req,
  output logic             scl_pull_low
);

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_SYNC = CNT_W'(SYNC_LAT);

  scl_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] low_last, high_last;

  // Named internal events
  logic low_done, high_done, ext_cut, stretch_wait, hold_active, high_start;

  assign low_last  = CNT_W'(last_tick(clamp_count(32'(low_count),  32'(MIN_COUNT))));
  assign high_last = CNT_W'(last_tick(clamp_count(32'(high_count), 32'(MIN_COUNT))));

  assign low_done     = (phase_q == PH_LOW)  && (cnt_q >= low_last);
  assign high_done    = (phase_q == PH_HIGH) && (cnt_q >= high_last);
  assign ext_cut      = (phase_q == PH_HIGH) && !scl_s;
  assign stretch_wait = (phase_q == PH_WAIT) && !scl_s;
  assign hold_active  = low_done && hold_req;
  assign high_start   = (phase_q == PH_WAIT) && scl_s;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (!master_en) begin
      phase_d = PH_OFF;
      cnt_d   = CNT_ZERO;
    end else begin
      case (phase_q)
        PH_OFF: begin
          phase_d = PH_WAIT;
          cnt_d   = CNT_ZERO;
        end
        PH_LOW: begin
          if (low_done) begin
            if (!hold_req) begin
              phase_d = PH_WAIT;
              cnt_d   = CNT_ZERO;
            end
          end else begin
            cnt_d = cnt_q + CNT_ONE;
          end
        end
        PH_WAIT: begin
          if (high_start) begin
            phase_d = PH_HIGH;
            cnt_d   = CNT_SYNC;
          end
        end
        PH_HIGH: begin
          if (ext_cut) begin
            phase_d = PH_LOW;
            cnt_d   = CNT_SYNC;
          end else if (high_done) begin
            phase_d = PH_LOW;
            cnt_d   = CNT_ZERO;
          end else begin
            cnt_d = cnt_q + CNT_ONE;
          end
        end
        default: begin
          phase_d = PH_OFF;
          cnt_d   = CNT_ZERO;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OFF;
      cnt_q   <= CNT_ZERO;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign scl_pull_low = (phase_q == PH_LOW);

  // R1: master mode off releases the line
  a_r1_off_releases: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |=> !scl_pull_low);
  // R6: no high count while the synchronized line is still low
  a_r6_no_high_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    stretch_wait |=> (phase_q != PH_HIGH));
  // R3: high phase only begins after the line was seen high
  a_r3_high_after_seen_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_HIGH) && ($past(phase_q) != PH_HIGH)) |-> $past(scl_s));
  // R5: another device pulling low ends the high phase
  a_r5_cut_pulls_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_cut && master_en) |=> scl_pull_low);
  // R7: a pending hold keeps the line low
  a_r7_hold_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_active && master_en) |=> scl_pull_low);

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_en,
  input  logic [CNT_W-1:0] low_count,
  input  logic [CNT_W-1:0] high_count,
  input  logic             scl_in,
  input  logic             hold_req,
  output logic             scl_pull_low,
  output logic             scl_rise,
  output logic             scl_fall
);

  // Synchronizer stages plus the phase register
  localparam int SYNC_LAT  = SYNC_STAGES + 1;
  localparam int MIN_COUNT = SYNC_LAT + 1;

  logic scl_s;

  scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .scl_s    (scl_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall)
  );

  scl_phase_fsm #(
    .CNT_W     (CNT_W),
    .SYNC_LAT  (SYNC_LAT),
    .MIN_COUNT (MIN_COUNT)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .master_en    (master_en),
    .low_count    (low_count),
    .high_count   (high_count),
    .scl_s        (scl_s),
    .hold_req     (hold_req),
    .scl_pull_low (scl_pull_low)
  );

  // R9: outputs idle while reset is applied
  always_comb begin
    if (!rst_n) begin
      a_r9_reset_idle: assert (!scl_pull_low && !scl_rise && !scl_fall);
    end
  end

endmodule

// File: tb/test_scl_clock_gen.sv
`timescale 1ns/1ps
module test_scl_clock_gen;
  localparam int CW = 16;
  // {low_count, high_count, expected low cycles, expected high cycles}
  localparam int VTAB [6][4] = '{
    '{5, 7, 5, 7},
    '{10, 4, 10, 4},
    '{2, 3, 4, 4},
    '{0, 1, 4, 4},
    '{20, 12, 20, 12},
    '{4, 9, 4, 9}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_en = 1'b0;
  logic hold_req = 1'b0;
  logic other_pull = 1'b0;
  logic [CW-1:0] low_count = CW'(8);
  logic [CW-1:0] high_count = CW'(8);
  logic scl_pull_low, scl_rise, scl_fall;
  logic scl_line;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  assign scl_line = !(scl_pull_low || other_pull);

  always #4 clk = ~clk;

  scl_clock_gen #(.CNT_W(CW)) i_scl_clock_gen (
    .clk(clk), .rst_n(rst_n), .master_en(master_en),
    .low_count(low_count), .high_count(high_count),
    .scl_in(scl_line), .hold_req(hold_req),
    .scl_pull_low(scl_pull_low), .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Count further negedge samples at level lvl; stops on the first other sample.
  task automatic count_run(input logic lvl, output int n);
    n = 0;
    @(negedge clk);
    while (scl_line == lvl) begin
      n++;
      @(negedge clk);
    end
  endtask

  // Return at the first low sample after a high sample.
  task automatic sync_to_fall;
    @(negedge clk);
    while (scl_line != 1'b1) @(negedge clk);
    while (scl_line != 1'b0) @(negedge clk);
  endtask

  task automatic measure(output int lo, output int hi);
    int n;
    sync_to_fall();
    count_run(1'b0, n);
    lo = 1 + n;
    count_run(1'b1, n);
    hi = 1 + n;
  endtask

  task automatic set_counts(input int lc, input int hc);
    @(posedge clk);
    #1;
    low_count  = CW'(lc);
    high_count = CW'(hc);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int lo, hi, n, cnt, pos;
    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9 outputs in reset", int'(scl_pull_low) + int'(scl_rise) + int'(scl_fall), 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    master_en = 1'b1;

    // R2 R3 R4: free-running periods from the vector table
    for (int v = 0; v < 6; v++) begin
      set_counts(VTAB[v][0], VTAB[v][1]);
      measure(lo, hi);
      measure(lo, hi);
      check($sformatf("R2/R4 low length vec %0d", v), lo, VTAB[v][2]);
      check($sformatf("R3/R4 high length vec %0d", v), hi, VTAB[v][3]);
    end

    // R8: edge pulses in the 3rd cycle of each level
    set_counts(8, 8);
    measure(lo, hi);
    sync_to_fall();
    cnt = 0; pos = 0;
    for (int s = 1; s <= 6; s++) begin
      if (s > 1) @(negedge clk);
      if (scl_fall) begin cnt++; pos = s; end
    end
    check("R8 fall pulse count", cnt, 1);
    check("R8 fall pulse position", pos, 3);
    while (scl_line != 1'b1) @(negedge clk);
    cnt = 0; pos = 0;
    for (int s = 1; s <= 6; s++) begin
      if (s > 1) @(negedge clk);
      if (scl_rise) begin cnt++; pos = s; end
    end
    check("R8 rise pulse count", cnt, 1);
    check("R8 rise pulse position", pos, 3);

    // R5: other device cuts the high phase short
    set_counts(10, 20);
    measure(lo, hi);
    while (scl_line != 1'b1) @(negedge clk);
    repeat (4) @(negedge clk);
    @(posedge clk);
    #1;
    other_pull = 1'b1;
    fork
      begin
        repeat (5) @(posedge clk);
        #1;
        other_pull = 1'b0;
      end
    join_none
    repeat (4) @(negedge clk);
    check("R5 pull asserted after cut", int'(scl_pull_low), 1);
    count_run(1'b0, n);
    check("R5 low length after cut", 4 + n, 10);
    count_run(1'b1, n);
    check("R5 next high length", 1 + n, 20);

    // R6: other device stretches the low phase
    set_counts(6, 8);
    measure(lo, hi);
    sync_to_fall();
    @(posedge clk);
    #1;
    other_pull = 1'b1;
    repeat (9) @(negedge clk);
    check("R6 released while line held", int'(scl_pull_low), 0);
    check("R6 line still low", int'(scl_line), 0);
    @(posedge clk);
    #1;
    other_pull = 1'b0;
    count_run(1'b1, n);
    check("R6 high length after stretch", n, 8);
    count_run(1'b0, n);
    check("R6 following low length", 1 + n, 6);

    // R7: hold request keeps the line low
    set_counts(6, 6);
    measure(lo, hi);
    sync_to_fall();
    @(posedge clk);
    #1;
    hold_req = 1'b1;
    cnt = 0;
    repeat (20) begin
      @(negedge clk);
      if (scl_pull_low) cnt++;
    end
    check("R7 held low while flag set", cnt, 20);
    @(posedge clk);
    #1;
    hold_req = 1'b0;
    @(negedge clk);
    check("R7 still low in clear cycle", int'(scl_pull_low), 1);
    @(negedge clk);
    check("R7 released after clear", int'(scl_pull_low), 0);
    count_run(1'b1, n);
    check("R7 high after release", 1 + n, 6);

    // R1: leaving master mode releases the line
    sync_to_fall();
    @(posedge clk);
    #1;
    master_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 pull off after disable", int'(scl_pull_low), 0);
    cnt = 0;
    repeat (30) begin
      @(negedge clk);
      if (scl_line) cnt++;
    end
    check("R1 line stays released", cnt, 30);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule